// File: doc/BRIEF.md
# Modem Status Loopback Generator

This block keeps the eight-bit modem status byte of a serial port controller. The upper nibble holds the four line states (clear-to-send, data-set-ready, ring, carrier) and the lower nibble holds one sticky change flag per line. When the loop bit of the modem control byte is set, the four modem control outputs are folded back as line states with a crossed pairing: the two auxiliary outputs feed carrier and ring, request-to-send feeds clear-to-send, and data-terminal-ready feeds data-set-ready. When the loop bit is clear, the line states come from an external four-bit modem input vector, which is first passed through a synchronizer.

Change flags for clear-to-send, data-set-ready and carrier are raised on any change of their line. The ring flag is raised only when the ring line goes from 1 to 0. Flags stay set until a read of the status byte, signalled by a one-cycle clear pulse. If a new change occurs in the same cycle as that pulse, the new change is kept.

Top module: `uart_modem_loopback`

## Requirements
- R1: With control bit 4 (loop) set, control bit 3 appears on status bit 7 (carrier) and control bit 2 appears on status bit 6 (ring) one clock edge after the control byte is applied.
- R2: With the loop bit set, control bit 1 appears on status bit 4 (clear-to-send) and control bit 0 appears on status bit 5 (data-set-ready) one clock edge later.
- R3: With the loop bit clear, the control byte has no effect on the status byte; external input bit 0 (clear-to-send), bit 1 (data-set-ready), bit 2 (ring) and bit 3 (carrier) reach status bits 4, 5, 6 and 7 after SYNC_STAGES+1 clock edges, and not earlier.
- R4: Status bit 0, bit 1 and bit 3 are raised when clear-to-send, data-set-ready and carrier respectively change value in either direction.
- R5: Status bit 2 is raised only when the ring line falls from 1 to 0; a rising ring line leaves it unchanged.
- R6: A raised change flag stays set, with no clear pulse, while the lines are steady.
- R7: A one-cycle clear pulse zeroes all four change flags on the next edge while the line-state bits keep showing their source.
- R8: A change occurring in the same cycle as the clear pulse leaves its own flag set after that edge; the other flags are cleared.
- R9: After reset the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mctl_i | input | 8 | Modem control byte: bit 0 DTR, bit 1 RTS, bit 2 aux 1, bit 3 aux 2, bit 4 loop |
| ext_lines_i | input | 4 | External modem inputs: bit 0 CTS, bit 1 DSR, bit 2 ring, bit 3 carrier |
| rd_clr_i | input | 1 | One-cycle pulse marking a read of the status byte |
| msr_o | output | 8 | Status byte: line states in bits 7..4, change flags in bits 3..0 |

## Verification
The properties assume the clear pulse is a synchronous single-cycle strobe and that the control byte is a registered value, stable between edges; the external vector may change at any time since it passes the synchronizer first. The bench changes all inputs only at the falling clock edge, keeps each clear pulse one cycle long, and waits the full synchronizer latency before judging any external-input effect, so the one-edge loopback timing and the multi-edge external timing are checked separately.

// File: rtl/uart_modem_loopback_pkg.sv
package uart_modem_loopback_pkg;

  localparam int unsigned LINE_N = 4;
  localparam int unsigned CTRL_W = 8;
  localparam int unsigned STAT_W = 2 * LINE_N;

  // Control byte bit positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_AUX1 = 2;
  localparam int unsigned C_AUX2 = 3;
  localparam int unsigned C_LOOP = 4;

  // Line order inside the nibble: bit 0 cts, 1 dsr, 2 ring, 3 carrier
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  // Lines whose flag reacts only to a 1->0 transition
  localparam logic [LINE_N-1:0] FALL_ONLY_MASK = 4'b0100;

endpackage

// File: rtl/uart_modem_loopback_sync.sv
module uart_modem_loopback_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/uart_modem_loopback_route.sv
module uart_modem_loopback_route
  import uart_modem_loopback_pkg::*;
(
  input  logic [CTRL_W-1:0] mctl_i,
  input  line_t             ext_i,
  output line_t             line_o
);

  line_t looped;

  // Crossed pairing of the control outputs onto the status inputs
  always_comb begin
    looped.cts = mctl_i[C_RTS];
    looped.dsr = mctl_i[C_DTR];
    looped.ri  = mctl_i[C_AUX1];
    looped.dcd = mctl_i[C_AUX2];
  end

  assign line_o = mctl_i[C_LOOP] ? looped : ext_i;

endmodule

// File: rtl/uart_modem_loopback_delta.sv
module uart_modem_loopback_delta #(
  parameter int unsigned       WIDTH     = 4,
  parameter logic [WIDTH-1:0]  FALL_ONLY = '0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] evt_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (FALL_ONLY[b]) begin : g_fall
        assign evt_o[b] = cur_i[b] & ~nxt_i[b];
      end else begin : g_any
        assign evt_o[b] = cur_i[b] ^ nxt_i[b];
      end
    end
  endgenerate

endmodule

// File: rtl/uart_modem_loopback.sv
module uart_modem_loopback
  import uart_modem_loopback_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] mctl_i,
  input  logic [LINE_N-1:0] ext_lines_i,
  input  logic              rd_clr_i,
  output logic [STAT_W-1:0] msr_o
);

  logic [LINE_N-1:0] ext_sync;
  line_t             line_src;
  line_t             line_q, line_d;
  logic [LINE_N-1:0] flag_q, flag_d;
  logic [LINE_N-1:0] evt;
  logic              upd_en;

  uart_modem_loopback_sync #(
    .WIDTH  (LINE_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_lines_i),
    .q_o   (ext_sync)
  );

  uart_modem_loopback_route u_route (
    .mctl_i (mctl_i),
    .ext_i  (line_t'(ext_sync)),
    .line_o (line_src)
  );

  uart_modem_loopback_delta #(
    .WIDTH     (LINE_N),
    .FALL_ONLY (FALL_ONLY_MASK)
  ) u_delta (
    .cur_i (line_q),
    .nxt_i (line_src),
    .evt_o (evt)
  );

  // Next state: line bits rewritten from source, flags sticky, new event wins
  always_comb begin
    line_d = line_src;
    flag_d = (rd_clr_i ? '0 : flag_q) | evt;
    upd_en = rd_clr_i | (line_d != line_q) | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      flag_q <= '0;
    end else if (upd_en) begin
      line_q <= line_d;
      flag_q <= flag_d;
    end
  end

  assign msr_o = {line_q, flag_q};

endmodule

// File: rtl/uart_modem_loopback_chk.sv
module uart_modem_loopback_chk
  import uart_modem_loopback_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] mctl_i,
  input logic              rd_clr_i,
  input logic [STAT_W-1:0] msr_o
);

  a_r1_aux_to_dcd_ri: assert property (@(posedge clk) disable iff (!rst_n)
    mctl_i[C_LOOP] |=> (msr_o[7] == $past(mctl_i[C_AUX2])) && (msr_o[6] == $past(mctl_i[C_AUX1])));

  a_r2_rts_dtr_cross: assert property (@(posedge clk) disable iff (!rst_n)
    mctl_i[C_LOOP] |=> (msr_o[4] == $past(mctl_i[C_RTS])) && (msr_o[5] == $past(mctl_i[C_DTR])));

  a_r4_cts_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_o[0]) |-> (msr_o[4] != $past(msr_o[4])));

  a_r5_ring_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_o[2]) |-> $fell(msr_o[6]));

  a_r6_sticky_dcd: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[3] && !rd_clr_i) |=> msr_o[3]);

  a_r7_clear_dsr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (msr_o[1] == (msr_o[5] != $past(msr_o[5]))));

  a_r8_clear_cts_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (msr_o[0] == (msr_o[4] != $past(msr_o[4]))));

endmodule

bind uart_modem_loopback uart_modem_loopback_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mctl_i   (mctl_i),
  .rd_clr_i (rd_clr_i),
  .msr_o    (msr_o)
);

// File: tb/uart_modem_loopback_tb.sv
module uart_modem_loopback_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] mctl;
  logic [3:0] ext;
  logic       rd_clr;
  logic [7:0] msr;

  int total = 0;
  int bad   = 0;

  uart_modem_loopback #(.SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mctl_i      (mctl),
    .ext_lines_i (ext),
    .rd_clr_i    (rd_clr),
    .msr_o       (msr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (msr !== exp) begin
      bad++;
      $display("FAIL %s: msr=0x%02h expected 0x%02h", req, msr, exp);
    end
  endtask

  task automatic clear_pulse();
    rd_clr = 1'b1;
    step(1);
    rd_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R9", 8'h00);
  endtask

  task automatic t_loop_map();
    mctl = 8'h1A;            // loop, aux2, rts
    step(1);
    check("R1 R2 R4", 8'h99);
    clear_pulse();
    check("R7", 8'h90);
    mctl = 8'h15;            // loop, aux1, dtr
    step(1);
    check("R1 R2 R5 rising ring no flag", 8'h6B);
    clear_pulse();
    check("R7", 8'h60);
    mctl = 8'h10;            // all looped lines low
    step(1);
    check("R5 ring fall", 8'h06);
  endtask

  task automatic t_sticky_and_race();
    step(4);
    check("R6", 8'h06);
    mctl = 8'h11;            // dsr rises during clear
    clear_pulse();
    check("R8", 8'h22);
    clear_pulse();
    check("R7", 8'h20);
  endtask

  task automatic t_external();
    mctl = 8'h0F;            // loop off, control bits must be ignored
    step(1);
    check("R3 control ignored", 8'h02);
    clear_pulse();
    check("R7", 8'h00);
    ext = 4'b1001;           // cts, carrier
    step(2);
    check("R3 latency not early", 8'h00);
    step(1);
    check("R3 R4", 8'h99);
    clear_pulse();
    check("R7", 8'h90);
    ext = 4'b0100;           // ring only
    step(3);
    check("R3 R4 R5", 8'h49);
    clear_pulse();
    ext = 4'b0000;
    step(3);
    check("R5 ext ring fall", 8'h04);
  endtask

  initial begin
    rst_n  = 1'b0;
    mctl   = 8'h00;
    ext    = 4'h0;
    rd_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_loop_map();
    t_sticky_and_race();
    t_external();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule